// File: doc/BRIEF.md
# Variable Transport Delay Sequencer

This block turns an 8-bit sampling ADC, a memory and an 8-bit DAC into a pure time-delay element for analogue simulation. A restart clears both memory pointers, fires one start pulse at an external delay timer and opens a fill phase. In the fill phase the block strobes the ADC once per sampling period and stores each converted word in order, up to a fixed cap. When the timer's return line falls, the block switches to playback at the next period boundary. In each playback period it first writes to the DAC the word stored a fixed number of periods earlier, then takes and stores a new sample. After a fixed number of playback periods it goes idle and raises a done flag.

The delay is not a register depth. It is the number of samples taken before the timer edge, because the read pointer starts at zero and the write pointer starts wherever the fill stopped. The converters and the timer are outside the block. The restart input is honoured in every state.

Top module: `transport_delay_seq`

## Requirements
- R1: After reset, `done_o` is 1, `adc_start_o` and `timer_start_o` are 0, and `dac_data_o` is 0.
- R2: A restart pulse clears `done_o` in the next cycle. It also drives exactly one `timer_start_o` pulse of `TPULSE_CYC` cycles, starting in the cycle after the restart.
- R3: While filling or in playback, each sampling period of `PERIOD_CYC` cycles opens with one `adc_start_o` pulse of `STROBE_CYC` cycles. `adc_data_i` is stored `STROBE_CYC + CONV_CYC` cycles after the period starts.
- R4: The fill phase stores at most `FILL_MAX` samples. Once the cap is reached, no further ADC strobes are issued until playback begins.
- R5: A high-to-low transition on `timer_ret_i` during the fill phase or the capped wait starts playback at the first period boundary after the edge. The first playback strobe comes within one sampling period of the edge.
- R6: In playback period p (counted from 0), `dac_data_o` shows the p-th sample stored since the restart, from the second cycle of that period onward.
- R7: Every playback period also stores a new sample behind the earlier ones. Playback periods beyond the fill count therefore output samples that were captured during playback.
- R8: Playback lasts exactly `PLAY_ITERS` periods. The block then idles with `done_o` high, issues no strobes, and holds the last DAC word.
- R9: A falling edge of `timer_ret_i` during playback or idle has no effect on strobes, DAC words, playback length or `done_o`.
- R10: `dac_data_o` changes only in playback. During fill and wait it keeps its previous value.
- R11: The read pointer never passes the write pointer, and neither pointer wraps within one run (`FILL_MAX + PLAY_ITERS <= MEM_DEPTH`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| restart_i | input | 1 | One-cycle pulse that begins a new run |
| adc_start_o | output | 1 | Conversion strobe to the ADC |
| adc_data_i | input | 8 | Converted ADC word |
| dac_data_o | output | 8 | Word held at the DAC input |
| timer_start_o | output | 1 | Start pulse to the external delay timer |
| timer_ret_i | input | 1 | Timer return line; its falling edge ends the fill phase |
| done_o | output | 1 | High while idle |

## Verification
A pointer or phase error shows up at the DAC within one sampling period, because every playback period compares the DAC word against the sample list the bench captured at each strobe. A bad fill cap or bad edge handling changes the count of strobes seen before the edge, or the time to the first playback strobe. A broken iteration counter changes the total strobe count and the moment `done_o` rises. A DAC write outside playback is caught on the first cycle the DAC word moves while the bench still expects the fill phase.

// File: rtl/tdly_pkg.sv
package tdly_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_HOLD = 2'd2,
    ST_PLAY = 2'd3
  } tdly_state_e;
endpackage

// File: rtl/tdly_mem.sv
// Simple dual-port sample store: one write port, one registered read port.
module tdly_mem #(
  parameter int DW    = 8,
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/tdly_timebase.sv
// Sampling-period counter and the event ticks derived from its phase.
module tdly_timebase #(
  parameter int PERIOD_CYC = 3650000,
  parameter int STROBE_CYC = 100,
  parameter int CAP_CYC    = 1350,
  localparam int PCW = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic tick_start,
  output logic tick_dac,
  output logic tick_cap,
  output logic tick_end,
  output logic in_strobe
);
  localparam logic [PCW-1:0] LAST = PCW'(PERIOD_CYC - 1);
  localparam logic [PCW-1:0] CAP  = PCW'(CAP_CYC);
  localparam logic [PCW-1:0] STB  = PCW'(STROBE_CYC);

  logic [PCW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst || clr || !run) phase <= '0;
    else if (phase == LAST) phase <= '0;
    else phase <= phase + 1'b1;
  end

  assign tick_start = run && (phase == '0);
  assign tick_dac   = run && (phase == PCW'(1));
  assign tick_cap   = run && (phase == CAP);
  assign tick_end   = run && (phase == LAST);
  assign in_strobe  = run && (phase < STB);
endmodule

// File: rtl/tdly_edge.sv
// Two-flop synchronizer with high-to-low edge detect.
module tdly_edge (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic fall_o
);
  logic s1, s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= din;
      s2 <= s1;
    end
  end

  assign fall_o = s2 && !s1;
endmodule

// File: rtl/transport_delay_seq.sv
module transport_delay_seq #(
  parameter int DATA_W     = 8,
  parameter int MEM_DEPTH  = 512,
  parameter int PERIOD_CYC = 3650000,
  parameter int STROBE_CYC = 100,
  parameter int CONV_CYC   = 1250,
  parameter int TPULSE_CYC = 100,
  parameter int FILL_MAX   = 90,
  parameter int PLAY_ITERS = 384
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart_i,
  output logic              adc_start_o,
  input  logic [DATA_W-1:0] adc_data_i,
  output logic [DATA_W-1:0] dac_data_o,
  output logic              timer_start_o,
  input  logic              timer_ret_i,
  output logic              done_o
);
  import tdly_pkg::*;

  localparam int AW      = $clog2(MEM_DEPTH);
  localparam int CAP_CYC = STROBE_CYC + CONV_CYC;
  localparam int ITW     = $clog2(PLAY_ITERS + 1);
  localparam int TPW     = $clog2(TPULSE_CYC + 1);

  tdly_state_e       state;
  logic [AW-1:0]     wptr, rptr;
  logic [ITW-1:0]    iter;
  logic [TPW-1:0]    tp_cnt;
  logic              pend;

  logic tick_start, tick_dac, tick_cap, tick_end, in_strobe;
  logic ret_fall;
  logic run, sample_en, in_play, mem_we, mem_re, dac_ld;
  logic [DATA_W-1:0] rd_word;

  assign run       = (state != ST_IDLE);
  assign in_play   = (state == ST_PLAY);
  assign sample_en = (state == ST_FILL) || in_play;
  assign mem_we    = tick_cap && sample_en;
  assign mem_re    = tick_start && in_play;
  assign dac_ld    = tick_dac && in_play;

  tdly_timebase #(
    .PERIOD_CYC (PERIOD_CYC),
    .STROBE_CYC (STROBE_CYC),
    .CAP_CYC    (CAP_CYC)
  ) u_tb (
    .clk        (clk),
    .rst        (rst),
    .clr        (restart_i),
    .run        (run),
    .tick_start (tick_start),
    .tick_dac   (tick_dac),
    .tick_cap   (tick_cap),
    .tick_end   (tick_end),
    .in_strobe  (in_strobe)
  );

  tdly_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .din    (timer_ret_i),
    .fall_o (ret_fall)
  );

  tdly_mem #(
    .DW    (DATA_W),
    .DEPTH (MEM_DEPTH)
  ) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (wptr),
    .wdata (adc_data_i),
    .re    (mem_re),
    .raddr (rptr),
    .rdata (rd_word)
  );

  // Timer start pulse
  always_ff @(posedge clk) begin
    if (rst) begin
      timer_start_o <= 1'b0;
      tp_cnt        <= '0;
    end else if (restart_i) begin
      timer_start_o <= 1'b1;
      tp_cnt        <= TPW'(TPULSE_CYC - 1);
    end else if (tp_cnt != '0) begin
      tp_cnt <= tp_cnt - 1'b1;
    end else begin
      timer_start_o <= 1'b0;
    end
  end

  // Sequencer, pointers and registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      wptr        <= '0;
      rptr        <= '0;
      iter        <= '0;
      pend        <= 1'b0;
      adc_start_o <= 1'b0;
      dac_data_o  <= '0;
      done_o      <= 1'b1;
    end else if (restart_i) begin
      state       <= ST_FILL;
      wptr        <= '0;
      rptr        <= '0;
      iter        <= '0;
      pend        <= 1'b0;
      adc_start_o <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      adc_start_o <= in_strobe && sample_en;

      if (ret_fall && (state == ST_FILL || state == ST_HOLD)) pend <= 1'b1;
      if (mem_we) wptr <= wptr + 1'b1;
      if (dac_ld) begin
        dac_data_o <= rd_word;
        rptr       <= rptr + 1'b1;
      end

      unique case (state)
        ST_FILL: begin
          if (mem_we && wptr == AW'(FILL_MAX - 1)) state <= ST_HOLD;
          if (tick_end && pend) begin
            state <= ST_PLAY;
            pend  <= 1'b0;
          end
        end
        ST_HOLD: begin
          if (tick_end && pend) begin
            state <= ST_PLAY;
            pend  <= 1'b0;
          end
        end
        ST_PLAY: begin
          if (mem_we) iter <= iter + 1'b1;
          if (tick_end && iter == ITW'(PLAY_ITERS)) begin
            state  <= ST_IDLE;
            done_o <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tdly_chk.sv
module tdly_chk #(
  parameter int AW       = 9,
  parameter int FILL_MAX = 90
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  restart_i,
  input logic                  adc_start_o,
  input logic                  timer_start_o,
  input logic                  done_o,
  input logic [7:0]            dac_data_o,
  input tdly_pkg::tdly_state_e st,
  input logic [AW-1:0]         wptr,
  input logic [AW-1:0]         rptr
);
  import tdly_pkg::*;

  a_r2_timer_from_restart: assert property (@(posedge clk) disable iff (rst)
    $rose(timer_start_o) |-> $past(restart_i));

  a_r2_restart_clears_done: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> !done_o);

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !adc_start_o);

  a_r10_dac_only_in_play: assert property (@(posedge clk) disable iff (rst)
    !$stable(dac_data_o) |-> ($past(st) == ST_PLAY));

  a_r11_ptr_order: assert property (@(posedge clk) disable iff (rst)
    rptr <= wptr);

  a_r4_fill_cap: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FILL || st == ST_HOLD) |-> (wptr <= AW'(FILL_MAX)));
endmodule

bind transport_delay_seq tdly_chk #(
  .AW       (AW),
  .FILL_MAX (FILL_MAX)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .restart_i     (restart_i),
  .adc_start_o   (adc_start_o),
  .timer_start_o (timer_start_o),
  .done_o        (done_o),
  .dac_data_o    (dac_data_o),
  .st            (state),
  .wptr          (wptr),
  .rptr          (rptr)
);

// File: tb/sim_transport_delay_seq.sv
module sim_transport_delay_seq;
  localparam int P     = 24;
  localparam int STB   = 3;
  localparam int CONV  = 5;
  localparam int TP    = 4;
  localparam int FMAX  = 10;
  localparam int PITER = 40;
  localparam int DEPTH = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       restart_i = 1'b0;
  logic       timer_ret_i = 1'b0;
  logic [7:0] adc_data_i = 8'h00;
  logic       adc_start_o, timer_start_o, done_o;
  logic [7:0] dac_data_o;

  always #2 clk = ~clk;

  transport_delay_seq #(
    .DATA_W (8), .MEM_DEPTH (DEPTH), .PERIOD_CYC (P), .STROBE_CYC (STB),
    .CONV_CYC (CONV), .TPULSE_CYC (TP), .FILL_MAX (FMAX), .PLAY_ITERS (PITER)
  ) u0 (
    .clk (clk), .rst (rst), .restart_i (restart_i), .adc_start_o (adc_start_o),
    .adc_data_i (adc_data_i), .dac_data_o (dac_data_o),
    .timer_start_o (timer_start_o), .timer_ret_i (timer_ret_i), .done_o (done_o)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit prev_adc = 0, prev_tmr = 0, in_play = 0;
  logic [7:0] prev_dac = 8'h00;
  logic [7:0] stored [0:127];
  int nstored, strobe_cnt, strobe_len, play_idx, tp_len, tp_pulses, n_fill;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_sim;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic int exp_fill(input int k);
    return (k + 1 < FMAX) ? k + 1 : FMAX;
  endfunction

  // One cycle: advance to the falling edge, model ADC and timer, monitor.
  task automatic tick;
    logic [7:0] v;
    @(negedge clk);
    cyc++;
    if (adc_start_o && !prev_adc) begin
      v = 8'($urandom);
      adc_data_i = v;
      stored[nstored] = v;
      nstored++;
      strobe_cnt++;
      strobe_len = 1;
    end else if (adc_start_o) begin
      strobe_len++;
    end
    if (!adc_start_o && prev_adc) begin
      check(strobe_len == STB, "R3 strobe width", strobe_len, STB);
      if (in_play) begin
        if (play_idx >= n_fill)
          check(dac_data_o == stored[play_idx], "R7 playback of replayed sample",
                dac_data_o, stored[play_idx]);
        else
          check(dac_data_o == stored[play_idx], "R6 playback order",
                dac_data_o, stored[play_idx]);
        play_idx++;
      end
    end
    if (timer_start_o) begin
      tp_len++;
      timer_ret_i = 1'b1;
    end
    if (!timer_start_o && prev_tmr) tp_pulses++;
    if (dac_data_o !== prev_dac)
      check(in_play, "R10 DAC moved outside playback", dac_data_o, prev_dac);
    prev_adc = adc_start_o;
    prev_tmr = timer_start_o;
    prev_dac = dac_data_o;
  endtask

  task automatic run_case(input int k, input bit noisy);
    int c0, te, sc;
    nstored = 0; strobe_cnt = 0; strobe_len = 0; play_idx = 0;
    tp_len = 0; tp_pulses = 0; in_play = 0; n_fill = 0;
    restart_i = 1'b1;
    tick;
    restart_i = 1'b0;
    check(done_o == 1'b0, "R2 done cleared by restart", done_o, 0);
    while (strobe_cnt < 1) tick;
    c0 = cyc;
    while (cyc < c0 + k * P + P / 2) tick;
    timer_ret_i = 1'b0;          // timer return edge
    in_play = 1'b1;
    te = cyc;
    n_fill = strobe_cnt;
    check(n_fill == exp_fill(k), "R4 fill count before edge", n_fill, exp_fill(k));
    check(tp_pulses == 1, "R2 one timer pulse", tp_pulses, 1);
    check(tp_len == TP, "R2 timer pulse width", tp_len, TP);
    while (strobe_cnt < n_fill + 1) tick;
    check((cyc - te) >= 1 && (cyc - te) <= P + 3, "R5 playback start latency", cyc - te, P);
    if (noisy) begin
      repeat (2 * P) tick;
      timer_ret_i = 1'b1;        // R9: edge during playback
      repeat (P / 3) tick;
      timer_ret_i = 1'b0;
    end
    while (play_idx < PITER) tick;
    repeat (3 * P) tick;
    check(strobe_cnt == n_fill + PITER, "R8 playback length", strobe_cnt, n_fill + PITER);
    check(done_o == 1'b1, "R8 done after playback", done_o, 1);
    check(dac_data_o == stored[PITER - 1], "R8 DAC holds last word", dac_data_o, stored[PITER - 1]);
    sc = strobe_cnt;
    timer_ret_i = 1'b1;          // R9: edge while idle
    repeat (5) tick;
    timer_ret_i = 1'b0;
    repeat (2 * P) tick;
    check(strobe_cnt == sc, "R9 idle edge starts nothing", strobe_cnt, sc);
    check(done_o == 1'b1, "R9 idle edge keeps done", done_o, 1);
    check(dac_data_o == stored[PITER - 1], "R9 idle edge keeps DAC", dac_data_o, stored[PITER - 1]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finish_sim;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    tick;
    check(done_o == 1'b1, "R1 reset done", done_o, 1);
    check(adc_start_o == 1'b0, "R1 reset strobe", adc_start_o, 0);
    check(timer_start_o == 1'b0, "R1 reset timer pulse", timer_start_o, 0);
    check(dac_data_o == 8'h00, "R1 reset DAC", dac_data_o, 0);
    // Directed corners: earliest edge, exactly at cap, past cap (R4 wait)
    run_case(0, 1'b1);
    run_case(FMAX - 1, 1'b0);
    run_case(FMAX + 3, 1'b1);    // R11: longest run, FMAX + PITER <= DEPTH
    for (int i = 0; i < 4; i++) run_case($urandom_range(0, FMAX + 4), i[0]);
    finish_sim;
  end
endmodule